// File: doc/BRIEF.md
# Sparse Index Stream Merger

The merger sits between two indirect stream lanes and a compute datapath. Each lane presents a sorted stream of index/value elements taken along the major axis of a compressed sparse operand. Row-, column- and fiber-compressed layouts all reduce to this form. The merger walks both streams together by comparing their head indices and forwards value pairs to the compute unit. It runs in one of two modes. In intersection mode, only elements whose indices coincide are forwarded. In union mode, every distinct index is forwarded, and the absent side is filled with zero.

A lane marks its final element with a last flag. When a session completes, the merger emits a single end beat on its output. An optional second output stream carries the joint index of every forwarded pair, so a sparse result can be written with its own index list. The compared index width is set at run time to 8, 16 or 32 bits. Index bits above the chosen width are ignored.

Top module: `idx_merge_unit`

## Requirements
- R1: `cfg_iw` selects the compared index width: 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. Bits above that width are ignored when comparing, and they read as zero on `x_idx`.
- R2: In intersection mode (`cfg_mode`=0), a pair beat is emitted only for an index that both lanes carry, holding `a_val` in `p_va` and `b_val` in `p_vb`. Unmatched elements are consumed without any output. Lanes supply strictly ascending trimmed indices, and pairs leave in ascending index order.
- R3: In union mode (`cfg_mode`=1), every distinct index of either lane produces exactly one pair beat, in ascending order. The lane that lacks that index contributes a zero value.
- R4: In intersection mode, once either lane's last element has been consumed, the other lane is consumed up to its own last element with no pair output. A single end beat then follows.
- R5: In union mode, after one lane ends, the other lane's remaining elements are each forwarded with zero fill. The end beat follows after both last elements.
- R6: An end beat has `p_end`=1 and both `p_va` and `p_vb` equal to zero. Every other pair beat has `p_end`=0.
- R7: With `cfg_emit`=1, the index stream carries one trimmed index per pair beat in the same order, then one beat with `x_end`=1. With `cfg_emit`=0, `x_valid` stays low.
- R8: A pending beat holds its contents while its ready is low. A lane element whose consumption would produce a beat is not accepted until the output slot frees. No beat is lost or repeated.
- R9: After reset, `p_valid` and `x_valid` are low, and a lane's ready is never high while its valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | 0 intersection, 1 union |
| cfg_iw | input | 2 | Index width select |
| cfg_emit | input | 1 | Enable the joint index stream |
| a_valid | input | 1 | Lane A element valid |
| a_ready | output | 1 | Lane A element accepted |
| a_idx | input | 32 | Lane A index |
| a_val | input | VAL_W | Lane A value |
| a_last | input | 1 | Lane A final element |
| b_valid | input | 1 | Lane B element valid |
| b_ready | output | 1 | Lane B element accepted |
| b_idx | input | 32 | Lane B index |
| b_val | input | VAL_W | Lane B value |
| b_last | input | 1 | Lane B final element |
| p_valid | output | 1 | Pair beat valid |
| p_ready | input | 1 | Pair beat accepted |
| p_va | output | VAL_W | Lane A value or zero |
| p_vb | output | VAL_W | Lane B value or zero |
| p_end | output | 1 | End-of-session beat |
| x_valid | output | 1 | Index beat valid |
| x_ready | input | 1 | Index beat accepted |
| x_idx | output | 32 | Joint trimmed index |
| x_end | output | 1 | End-of-session index beat |

## Verification
The bench builds the unit with its defaults: 16-bit values and the index output stream present. With the index stream built in, `cfg_emit` can be switched at run time, so sessions with and without the joint index list are both exercised. All three compare widths are reached through `cfg_iw`, using indices whose upper bits are deliberately nonzero. Independent pseudo-random stalls on both output readies and gaps on the lanes expose the slot-occupied case, where a lane must wait, as well as end beats that coincide with other handshakes.

// File: rtl/idx_merge_pkg.sv
package idx_merge_pkg;
  localparam int unsigned IDXW = 32;

  typedef enum logic [1:0] {
    IW_8   = 2'd0,
    IW_16  = 2'd1,
    IW_32  = 2'd2,
    IW_32B = 2'd3
  } iw_sel_e;

  typedef enum logic {
    MODE_ISECT = 1'b0,
    MODE_UNION = 1'b1
  } merge_mode_e;

  typedef enum logic [1:0] {
    ORD_LT = 2'd0,
    ORD_EQ = 2'd1,
    ORD_GT = 2'd2
  } ord_e;

  // keep only the low bits that the selected width covers
  function automatic logic [IDXW-1:0] trim_idx(input logic [IDXW-1:0] raw,
                                              input iw_sel_e sel);
    unique case (sel)
      IW_8:    return {{(IDXW-8){1'b0}}, raw[7:0]};
      IW_16:   return {{(IDXW-16){1'b0}}, raw[15:0]};
      default: return raw;
    endcase
  endfunction

  function automatic ord_e order_of(input logic [IDXW-1:0] x,
                                    input logic [IDXW-1:0] y);
    if (x == y) return ORD_EQ;
    if (x < y)  return ORD_LT;
    return ORD_GT;
  endfunction
endpackage

// File: rtl/idx_merge_lane.sv
module idx_merge_lane
  import idx_merge_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  iw_sel_e         sel,
  input  logic [IDXW-1:0] raw_idx,
  input  logic            last,
  input  logic            pop,
  input  logic            clr,
  output logic [IDXW-1:0] m_idx,
  output logic            done
);
  logic            have_prev;
  logic [IDXW-1:0] prev_idx;

  assign m_idx = trim_idx(raw_idx, sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      have_prev <= 1'b0;
      prev_idx  <= '0;
    end else begin
      if (pop) begin
        prev_idx  <= m_idx;
        have_prev <= !last;
      end
      if (pop && last) done <= 1'b1;
      else if (clr)    done <= 1'b0;
    end
  end

  // R2: a lane's trimmed indices rise strictly inside one session
  a_r2_lane_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && have_prev) |-> (m_idx > prev_idx));

  // R4: a finished lane is not consumed again before the session closes
  a_r4_no_pop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> !pop);
endmodule

// File: rtl/idx_merge_pick.sv
module idx_merge_pick
  import idx_merge_pkg::*;
(
  input  merge_mode_e     mode,
  input  logic [1:0]      vld,
  input  logic [1:0]      done,
  input  logic [IDXW-1:0] idx_a,
  input  logic [IDXW-1:0] idx_b,
  input  logic            slot,
  output logic [1:0]      pop,
  output logic [1:0]      take,
  output logic            load,
  output logic            end_beat,
  output logic            discard,
  output logic [IDXW-1:0] out_idx
);
  always_comb begin
    pop      = 2'b00;
    take     = 2'b00;
    load     = 1'b0;
    end_beat = 1'b0;
    out_idx  = '0;
    if (done[0] && done[1]) begin
      load     = slot;
      end_beat = slot;
    end else if (done[0]) begin
      if (vld[1]) begin
        if (mode == MODE_ISECT) pop[1] = 1'b1;
        else if (slot) begin
          pop[1] = 1'b1; take[1] = 1'b1; load = 1'b1; out_idx = idx_b;
        end
      end
    end else if (done[1]) begin
      if (vld[0]) begin
        if (mode == MODE_ISECT) pop[0] = 1'b1;
        else if (slot) begin
          pop[0] = 1'b1; take[0] = 1'b1; load = 1'b1; out_idx = idx_a;
        end
      end
    end else if (vld[0] && vld[1]) begin
      unique case (order_of(idx_a, idx_b))
        ORD_EQ: if (slot) begin
          pop = 2'b11; take = 2'b11; load = 1'b1; out_idx = idx_a;
        end
        ORD_LT: begin
          if (mode == MODE_ISECT) pop[0] = 1'b1;
          else if (slot) begin
            pop[0] = 1'b1; take[0] = 1'b1; load = 1'b1; out_idx = idx_a;
          end
        end
        default: begin
          if (mode == MODE_ISECT) pop[1] = 1'b1;
          else if (slot) begin
            pop[1] = 1'b1; take[1] = 1'b1; load = 1'b1; out_idx = idx_b;
          end
        end
      endcase
    end
  end

  assign discard = (|pop) && !load;
endmodule

// File: rtl/idx_merge_obuf.sv
module idx_merge_obuf #(
  parameter int unsigned VAL_W = 16,
  parameter int unsigned IDX_W = 32,
  parameter bit          HAS_X = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VAL_W-1:0] ld_va,
  input  logic [VAL_W-1:0] ld_vb,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic             ld_end,
  input  logic             ld_x,
  input  logic             p_ready,
  input  logic             x_ready,
  output logic             slot,
  output logic             p_valid,
  output logic [VAL_W-1:0] p_va,
  output logic [VAL_W-1:0] p_vb,
  output logic             p_end,
  output logic             x_valid,
  output logic [IDX_W-1:0] x_idx,
  output logic             x_end
);
  logic             pend_p, pend_x, end_r;
  logic [VAL_W-1:0] va_r, vb_r;

  assign slot    = (!pend_p || p_ready) && (!pend_x || x_ready);
  assign p_valid = pend_p;
  assign p_va    = va_r;
  assign p_vb    = vb_r;
  assign p_end   = end_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_p <= 1'b0;
      va_r   <= '0;
      vb_r   <= '0;
      end_r  <= 1'b0;
    end else if (load) begin
      pend_p <= 1'b1;
      va_r   <= ld_va;
      vb_r   <= ld_vb;
      end_r  <= ld_end;
    end else if (p_ready) begin
      pend_p <= 1'b0;
    end
  end

  generate
    if (HAS_X) begin : g_xout
      logic [IDX_W-1:0] idx_r;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_x <= 1'b0;
          idx_r  <= '0;
        end else if (load) begin
          pend_x <= ld_x;
          idx_r  <= ld_idx;
        end else if (x_ready) begin
          pend_x <= 1'b0;
        end
      end
      assign x_idx = idx_r;
    end else begin : g_noxout
      assign pend_x = 1'b0;
      assign x_idx  = '0;
    end
  endgenerate

  assign x_valid = pend_x;
  assign x_end   = end_r;

  // R8: a stalled pair beat keeps its contents
  a_r8_hold_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_p && !p_ready) |=> (pend_p && $stable(va_r) && $stable(vb_r) && $stable(end_r)));

  // R8: a new beat is never written over an unaccepted one
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ((!pend_p || p_ready) && (!pend_x || x_ready)));

  // R6: end beats carry zero values
  a_r6_end_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_p && end_r) |-> (va_r == '0 && vb_r == '0));
endmodule

// File: rtl/idx_merge_unit.sv
module idx_merge_unit
  import idx_merge_pkg::*;
#(
  parameter int unsigned VAL_W = 16,
  parameter bit          HAS_X = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mode,
  input  logic [1:0]       cfg_iw,
  input  logic             cfg_emit,
  input  logic             a_valid,
  output logic             a_ready,
  input  logic [31:0]      a_idx,
  input  logic [VAL_W-1:0] a_val,
  input  logic             a_last,
  input  logic             b_valid,
  output logic             b_ready,
  input  logic [31:0]      b_idx,
  input  logic [VAL_W-1:0] b_val,
  input  logic             b_last,
  output logic             p_valid,
  input  logic             p_ready,
  output logic [VAL_W-1:0] p_va,
  output logic [VAL_W-1:0] p_vb,
  output logic             p_end,
  output logic             x_valid,
  input  logic             x_ready,
  output logic [31:0]      x_idx,
  output logic             x_end
);
  localparam int unsigned NLANE = 2;

  merge_mode_e     mode;
  iw_sel_e         iw;
  logic [NLANE-1:0] lv, ll, ldone, lpop, ltake;
  logic [IDXW-1:0] lraw [NLANE];
  logic [IDXW-1:0] lm   [NLANE];
  logic            slot, load, end_beat, discard, clr;
  logic [IDXW-1:0] sel_idx;
  logic [VAL_W-1:0] ld_va, ld_vb;

  assign mode    = merge_mode_e'(cfg_mode);
  assign iw      = iw_sel_e'(cfg_iw);
  assign lv      = {b_valid, a_valid};
  assign ll      = {b_last, a_last};
  assign lraw[0] = a_idx;
  assign lraw[1] = b_idx;
  assign clr     = load && end_beat;

  generate
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
      idx_merge_lane u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (iw),
        .raw_idx (lraw[g]),
        .last    (ll[g]),
        .pop     (lpop[g]),
        .clr     (clr),
        .m_idx   (lm[g]),
        .done    (ldone[g])
      );
    end
  endgenerate

  idx_merge_pick u_pick (
    .mode     (mode),
    .vld      (lv),
    .done     (ldone),
    .idx_a    (lm[0]),
    .idx_b    (lm[1]),
    .slot     (slot),
    .pop      (lpop),
    .take     (ltake),
    .load     (load),
    .end_beat (end_beat),
    .discard  (discard),
    .out_idx  (sel_idx)
  );

  assign a_ready = lpop[0];
  assign b_ready = lpop[1];
  assign ld_va   = ltake[0] ? a_val : '0;
  assign ld_vb   = ltake[1] ? b_val : '0;

  idx_merge_obuf #(.VAL_W(VAL_W), .IDX_W(IDXW), .HAS_X(HAS_X)) u_obuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .ld_va   (ld_va),
    .ld_vb   (ld_vb),
    .ld_idx  (sel_idx),
    .ld_end  (end_beat),
    .ld_x    (cfg_emit),
    .p_ready (p_ready),
    .x_ready (x_ready),
    .slot    (slot),
    .p_valid (p_valid),
    .p_va    (p_va),
    .p_vb    (p_vb),
    .p_end   (p_end),
    .x_valid (x_valid),
    .x_idx   (x_idx),
    .x_end   (x_end)
  );

  // R2: an intersection beat only comes from two equal heads
  a_r2_match_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ISECT && load && !end_beat) |-> (lm[0] == lm[1] && lpop == 2'b11));

  // R3: union mode consumes nothing without producing a beat
  a_r3_no_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UNION) |-> !discard);

  // R3: a one-sided union beat takes the smaller live head
  a_r3_smaller_first: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UNION && load && ltake == 2'b01 && !ldone[1]) |-> (lm[0] < lm[1]));

  // R7: the index stream stays quiet while it is disabled
  a_r7_x_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_emit && !x_valid) |=> !x_valid);

  // R9: a lane is never accepted without a valid element
  a_r9_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_ready -> a_valid) && (b_ready -> b_valid)));
endmodule

// File: tb/test_idx_merge_unit.sv
module test_idx_merge_unit;
  typedef struct packed {
    logic            mode;
    logic [1:0]      iw;
    logic            emit;
    logic [2:0]      na;
    logic [2:0]      nb;
    logic [3:0][31:0] ai;
    logic [3:0][31:0] bi;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 2'd2, 1'b0, 3'd4, 3'd4, {32'd7, 32'd5, 32'd3, 32'd1}, {32'd9, 32'd7, 32'd4, 32'd3}},
    '{1'b1, 2'd2, 1'b1, 3'd4, 3'd4, {32'd7, 32'd5, 32'd3, 32'd1}, {32'd9, 32'd7, 32'd4, 32'd3}},
    '{1'b0, 2'd1, 1'b1, 3'd3, 3'd2, {32'd0, 32'h12340008, 32'h00000005, 32'hABCD0002},
                                    {32'd0, 32'd0, 32'h77770008, 32'h00010002}},
    '{1'b1, 2'd0, 1'b1, 3'd3, 3'd2, {32'd0, 32'h09, 32'h7704, 32'h301},
                                    {32'd0, 32'd0, 32'hFF, 32'h504}},
    '{1'b0, 2'd2, 1'b1, 3'd2, 3'd2, {32'd0, 32'd0, 32'd2, 32'd1}, {32'd0, 32'd0, 32'd4, 32'd3}},
    '{1'b1, 2'd2, 1'b1, 3'd1, 3'd1, {32'd0, 32'd0, 32'd0, 32'd7}, {32'd0, 32'd0, 32'd0, 32'd7}},
    '{1'b1, 2'd2, 1'b0, 3'd1, 3'd4, {32'd0, 32'd0, 32'd0, 32'd100}, {32'd200, 32'd3, 32'd2, 32'd1}},
    '{1'b0, 2'd3, 1'b1, 3'd2, 3'd1, {32'd0, 32'd0, 32'hFFFFFFFF, 32'h80000000},
                                    {32'd0, 32'd0, 32'd0, 32'hFFFFFFFF}}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_mode = 1'b0, cfg_emit = 1'b0;
  logic [1:0] cfg_iw = 2'd2;
  logic a_valid = 1'b0, a_last = 1'b0, b_valid = 1'b0, b_last = 1'b0;
  logic [31:0] a_idx = '0, b_idx = '0;
  logic [15:0] a_val = '0, b_val = '0;
  logic p_ready = 1'b0, x_ready = 1'b0;
  logic a_ready, b_ready, p_valid, p_end, x_valid, x_end;
  logic [15:0] p_va, p_vb;
  logic [31:0] x_idx;

  int total = 0, bad = 0;
  logic [7:0] lf = 8'h5A;

  logic [15:0] rva [16], rvb [16], ea [16], eb [16];
  logic        rend [16], rxe [16];
  logic [31:0] rxi [16], ei [16];
  int got_p, got_x, ne;

  always #4 clk = ~clk;
  always @(posedge clk) lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};

  idx_merge_unit i_idx_merge_unit (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_iw(cfg_iw), .cfg_emit(cfg_emit),
    .a_valid(a_valid), .a_ready(a_ready), .a_idx(a_idx), .a_val(a_val), .a_last(a_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_idx(b_idx), .b_val(b_val), .b_last(b_last),
    .p_valid(p_valid), .p_ready(p_ready), .p_va(p_va), .p_vb(p_vb), .p_end(p_end),
    .x_valid(x_valid), .x_ready(x_ready), .x_idx(x_idx), .x_end(x_end)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] narrow(input logic [31:0] x, input logic [1:0] iw);
    if (iw == 2'd0) return x & 32'h0000_00FF;
    if (iw == 2'd1) return x & 32'h0000_FFFF;
    return x;
  endfunction

  function automatic logic [15:0] vala(input int c, input int k);
    return 16'hA000 + 16'(c * 16 + k);
  endfunction
  function automatic logic [15:0] valb(input int c, input int k);
    return 16'hB000 + 16'(c * 16 + k);
  endfunction

  task automatic model(input int c);
    int i = 0, j = 0;
    vec_t v = TBL[c];
    ne = 0;
    while (i < int'(v.na) && j < int'(v.nb)) begin
      logic [31:0] ma = narrow(v.ai[i], v.iw);
      logic [31:0] mb = narrow(v.bi[j], v.iw);
      if (ma == mb) begin
        ea[ne] = vala(c, i); eb[ne] = valb(c, j); ei[ne] = ma; ne++; i++; j++;
      end else if (ma < mb) begin
        if (v.mode) begin ea[ne] = vala(c, i); eb[ne] = '0; ei[ne] = ma; ne++; end
        i++;
      end else begin
        if (v.mode) begin ea[ne] = '0; eb[ne] = valb(c, j); ei[ne] = mb; ne++; end
        j++;
      end
    end
    if (v.mode) begin
      for (int k = i; k < int'(v.na); k++) begin
        ea[ne] = vala(c, k); eb[ne] = '0; ei[ne] = narrow(v.ai[k], v.iw); ne++;
      end
      for (int k = j; k < int'(v.nb); k++) begin
        ea[ne] = '0; eb[ne] = valb(c, k); ei[ne] = narrow(v.bi[k], v.iw); ne++;
      end
    end
  endtask

  task automatic drive_a(input int c);
    int k = 0;
    while (k < int'(TBL[c].na)) begin
      @(negedge clk);
      a_valid = 1'b1; a_idx = TBL[c].ai[k]; a_val = vala(c, k);
      a_last = (k == int'(TBL[c].na) - 1);
      #1;
      if (a_valid && a_ready) begin
        k++;
        if (lf[4] && k < int'(TBL[c].na)) begin @(negedge clk); a_valid = 1'b0; end
      end
    end
    @(negedge clk);
    a_valid = 1'b0;
  endtask

  task automatic drive_b(input int c);
    int k = 0;
    while (k < int'(TBL[c].nb)) begin
      @(negedge clk);
      b_valid = 1'b1; b_idx = TBL[c].bi[k]; b_val = valb(c, k);
      b_last = (k == int'(TBL[c].nb) - 1);
      #1;
      if (b_valid && b_ready) begin
        k++;
        if (lf[1] && k < int'(TBL[c].nb)) begin @(negedge clk); b_valid = 1'b0; end
      end
    end
    @(negedge clk);
    b_valid = 1'b0;
  endtask

  task automatic collect(input logic emit);
    logic pe = 1'b0, xe = 1'b0;
    got_p = 0; got_x = 0;
    while (!(pe && (xe || !emit))) begin
      @(negedge clk);
      p_ready = lf[0] | lf[5];
      x_ready = lf[2] | lf[6];
      #1;
      if (p_valid && p_ready) begin
        if (got_p < 16) begin rva[got_p] = p_va; rvb[got_p] = p_vb; rend[got_p] = p_end; end
        if (p_end) pe = 1'b1;
        got_p++;
      end
      if (x_valid && x_ready) begin
        if (got_x < 16) begin rxi[got_x] = x_idx; rxe[got_x] = x_end; end
        if (x_end) xe = 1'b1;
        got_x++;
      end
    end
    @(negedge clk);
    p_ready = 1'b0; x_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 p_valid", 64'(p_valid), 64'd0);
    chk("R9 x_valid", 64'(x_valid), 64'd0);
    chk("R9 a_ready", 64'(a_ready), 64'd0);
    chk("R9 b_ready", 64'(b_ready), 64'd0);

    for (int c = 0; c < NV; c++) begin
      string tm, te, ti;
      @(negedge clk);
      cfg_mode = TBL[c].mode; cfg_iw = TBL[c].iw; cfg_emit = TBL[c].emit;
      model(c);
      fork
        drive_a(c);
        drive_b(c);
        collect(TBL[c].emit);
      join
      tm = TBL[c].mode ? "R3" : "R2";
      te = TBL[c].mode ? "R5" : "R4";
      ti = (TBL[c].iw == 2'd2) ? "R7" : "R1";
      chk({te, " beat count"}, 64'(got_p), 64'(ne + 1));
      for (int k = 0; k < ne && k < 15; k++) begin
        chk({tm, " pair"}, {32'd0, rva[k], rvb[k]}, {32'd0, ea[k], eb[k]});
        chk("R6 data beat end flag", 64'(rend[k]), 64'd0);
      end
      chk({te, " end beat"}, 64'(rend[ne]), 64'd1);
      chk("R6 end values", {32'd0, rva[ne], rvb[ne]}, 64'd0);
      if (TBL[c].emit) begin
        chk("R7 index count", 64'(got_x), 64'(ne + 1));
        for (int k = 0; k < ne && k < 15; k++) chk({ti, " index"}, 64'(rxi[k]), 64'(ei[k]));
        chk("R7 index end", 64'(rxe[ne]), 64'd1);
      end else begin
        chk("R7 index stream off", 64'(got_x), 64'd0);
      end
    end

    // R8: held beat under a stalled pair stream, union mode
    @(negedge clk);
    cfg_mode = 1'b1; cfg_iw = 2'd2; cfg_emit = 1'b0; p_ready = 1'b0; x_ready = 1'b1;
    a_valid = 1'b1; a_idx = 32'd5; a_val = 16'h1111; a_last = 1'b1;
    b_valid = 1'b1; b_idx = 32'd9; b_val = 16'h2222; b_last = 1'b1;
    #1;
    chk("R8 first pop", 64'(a_ready), 64'd1);
    @(negedge clk);
    a_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R8 lane waits for slot", 64'(b_ready), 64'd0);
      chk("R8 beat held", {31'd0, p_valid, p_va, p_vb}, {31'd0, 1'b1, 16'h1111, 16'h0000});
      @(negedge clk);
    end
    p_ready = 1'b1;
    #1;
    chk("R8 lane proceeds", 64'(b_ready), 64'd1);
    @(negedge clk);
    b_valid = 1'b0;
    #1;
    chk("R5 drained beat", {31'd0, p_valid, p_va, p_vb}, {31'd0, 1'b1, 16'h0000, 16'h2222});
    @(negedge clk);
    #1;
    chk("R5 end after drain", {62'd0, p_valid, p_end}, 64'd3);
    @(negedge clk);
    #1;
    chk("R8 no repeat", 64'(p_valid), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule